// File: doc/BRIEF.md
# Ethernet Transmit Inter-Packet Gap Timer

This block spaces back-to-back frames on the transmit side of a 10/100 MAC. The MAC moves one nibble per transmit clock. The MAC pulses `frame_end_i` in the clock that carries the last CRC nibble of a frame. The timer then keeps `tx_ready_o` low until the gap has elapsed. The gap in transmit clocks is a fixed intrinsic delay of 6 plus a programmable 7-bit extension, so an extension of zero still yields 6 clocks. An extension of 0x12 gives 24 clocks, which is 0.96 µs at 100 Mb/s and 9.6 µs at 10 Mb/s.

A frame request pulse on `tx_req_i` that arrives during the gap, or while a frame is still in flight, is remembered. It is granted with a one-clock `tx_start_o` pulse in the first clock the gap allows. `tx_start_o` marks the clock of the first preamble nibble of the next frame. A request made while the timer is already ready is granted in the same clock.

The extension field sits in a 32-bit register port. Bits 6:0 hold the field. The upper bits are reserved, read as zero and ignore writes. A write completes in one clock, and the read data is combinational.

Top module: `ipg_timer`

## Requirements
- R1: After reset `tx_ready_o` is 1, `tx_start_o` is 0 and `reg_rdata_o` reads 0x00000012, so the standard 24-clock gap applies without setup.
- R2: If `frame_end_i` is high in clock c with field value F, then `tx_ready_o` is 0 in clocks c+1 through c+5+F and 1 again in clock c+6+F. For example, F = 0x01, 0x05, 0x09, 0x0D, 0x12 and 0x1D give 7, 11, 15, 19, 24 and 35 clocks.
- R3: With the field written to 0, the gap is exactly 6 clocks.
- R4: A `tx_req_i` pulse during a gap is held. `tx_start_o` then pulses in exactly clock c+6+F, and it stays 0 in every earlier clock of that gap.
- R5: A `tx_req_i` pulse while `tx_ready_o` is 1 raises `tx_start_o` in the same clock. `tx_ready_o` is then 0 from the next clock until the gap that follows the next `frame_end_i` has elapsed.
- R6: A register write during a gap does not change that gap. The new value applies from the next `frame_end_i` onward.
- R7: Writes to bits 31:7 are ignored, and those bits always read as 0.
- R8: A write with `reg_we_i` high in clock k shows on `reg_rdata_o` from clock k+1. In clock k the read data still shows the old value.
- R9: The largest field value, 0x7F, gives a gap of 133 clocks.
- R10: `tx_start_o` is only ever 1 while `tx_ready_o` is 1. Each request gives a single-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit nibble clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_end_i | input | 1 | High in the clock of the last CRC nibble |
| tx_req_i | input | 1 | Pulse requesting the next frame |
| tx_ready_o | output | 1 | Gap satisfied and no frame in flight |
| tx_start_o | output | 1 | Grant; clock of the first preamble nibble |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data (bits 6:0 used) |
| reg_rdata_o | output | 32 | Register read data |

## Verification
Results are due at three latencies:

- **Gap:** `tx_ready_o` is due exactly 6+F clocks after the `frame_end_i` clock. A held `tx_start_o` is due in that same clock.
- **Immediate grant:** `tx_start_o` is due in the same clock as the request, and `tx_ready_o` falls one clock later.
- **Register write:** the written value is due on `reg_rdata_o` one clock after `reg_we_i`.

The bench drives its inputs and samples its outputs one time unit after each rising edge, and it numbers the clocks from the strobe. A gap is counted as the first clock in which ready is seen high, so a gap one clock short or one clock long fails. The bench also samples the clock before each due clock to confirm that the output had not yet changed.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_BUSY = 2'd2
  } gap_state_e;
endpackage

// File: rtl/ipg_cfg_reg.sv
module ipg_cfg_reg #(
  parameter int          DATA_W    = 32,
  parameter int          FIELD_W   = 7,
  parameter logic [6:0]  FIELD_RST = 7'h12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [FIELD_W-1:0] wfield_i,
  output logic [FIELD_W-1:0] field_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int PAD_W = DATA_W - FIELD_W;

  logic [FIELD_W-1:0] field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   field_q <= FIELD_W'(FIELD_RST);
    else if (we_i) field_q <= wfield_i;
  end

  assign field_o = field_q;
  assign rdata_o = {{PAD_W{1'b0}}, field_q};
endmodule

// File: rtl/ipg_gap_counter.sv
module ipg_gap_counter
  import ipg_pkg::*;
#(
  parameter int FIELD_W   = 7,
  parameter int INTRINSIC = 6,
  parameter int CNT_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_end_i,
  input  logic               start_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic               ready_o
);
  gap_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    if (frame_end_i) begin
      // frame-end clock is clock 0 of the gap; the limit is latched here
      state_d = ST_GAP;
      cnt_d   = CNT_W'(1);
      lim_d   = CNT_W'(INTRINSIC) + CNT_W'(field_i);
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_d = ST_BUSY;
        ST_GAP: begin
          if (cnt_q == lim_q - CNT_W'(1)) state_d = ST_IDLE;
          else                            cnt_d   = cnt_q + CNT_W'(1);
        end
        ST_BUSY: ;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
    end
  end

  assign ready_o = (state_q == ST_IDLE);
endmodule

// File: rtl/ipg_req_hold.sv
module ipg_req_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ready_i,
  output logic start_o
);
  logic pend_q;

  assign start_o = ready_i & (req_i | pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (start_o) pend_q <= 1'b0;
    else if (req_i)   pend_q <= 1'b1;
  end
endmodule

// File: rtl/ipg_timer.sv
module ipg_timer #(
  parameter int         DATA_W    = 32,
  parameter int         FIELD_W   = 7,
  parameter int         INTRINSIC = 6,
  parameter logic [6:0] FIELD_RST = 7'h12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_end_i,
  input  logic              tx_req_i,
  output logic              tx_ready_o,
  output logic              tx_start_o,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int MAX_GAP = INTRINSIC + (1 << FIELD_W) - 1;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  logic [FIELD_W-1:0] field;
  logic               ready;
  logic               start;
  logic               unused_hi;

  assign unused_hi = ^reg_wdata_i[DATA_W-1:FIELD_W];

  ipg_cfg_reg #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .FIELD_RST(FIELD_RST)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i),
    .wfield_i(reg_wdata_i[FIELD_W-1:0]),
    .field_o(field), .rdata_o(reg_rdata_o)
  );

  ipg_gap_counter #(
    .FIELD_W(FIELD_W), .INTRINSIC(INTRINSIC), .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_end_i(frame_end_i),
    .start_i(start), .field_i(field), .ready_o(ready)
  );

  ipg_req_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(tx_req_i),
    .ready_i(ready), .start_o(start)
  );

  assign tx_ready_o = ready;
  assign tx_start_o = start;
endmodule

// File: rtl/ipg_timer_chk.sv
module ipg_timer_chk #(
  parameter int DATA_W    = 32,
  parameter int FIELD_W   = 7,
  parameter int INTRINSIC = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_end_i,
  input logic              tx_ready_o,
  input logic              tx_start_o,
  input logic              reg_we_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o
);
  localparam int W = $clog2(INTRINSIC + (1 << FIELD_W)) + 1;

  logic [W-1:0] obs_cnt, obs_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obs_cnt <= '0;
      obs_lim <= '0;
    end else if (frame_end_i) begin
      obs_cnt <= W'(1);
      obs_lim <= W'(INTRINSIC) + W'(reg_rdata_o[FIELD_W-1:0]);
    end else if (!tx_ready_o && obs_cnt != {W{1'b1}}) begin
      obs_cnt <= obs_cnt + W'(1);
    end
  end

  // R10
  start_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> tx_ready_o);

  // R5
  start_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_ready_o);

  // R2
  frame_end_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> !tx_ready_o);

  // R2
  gap_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) |-> obs_cnt == obs_lim);

  // R7
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DATA_W-1:FIELD_W] == '0);

  // R8
  write_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[FIELD_W-1:0] == $past(reg_wdata_i[FIELD_W-1:0]));
endmodule

bind ipg_timer ipg_timer_chk #(
  .DATA_W(DATA_W), .FIELD_W(FIELD_W), .INTRINSIC(INTRINSIC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_end_i(frame_end_i),
  .tx_ready_o(tx_ready_o), .tx_start_o(tx_start_o),
  .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
);

// File: tb/ipg_timer_tb_top.sv
module ipg_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_end_i = 1'b0;
  logic        tx_req_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic        tx_ready_o, tx_start_o;
  logic [31:0] reg_rdata_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ipg_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_end_i(frame_end_i),
    .tx_req_i(tx_req_i), .tx_ready_o(tx_ready_o), .tx_start_o(tx_start_o),
    .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_field(logic [31:0] val);
    reg_we_i = 1'b1;
    reg_wdata_i = val;
    step();
    reg_we_i = 1'b0;
  endtask

  // strobe frame end, return clocks until ready is first seen high
  task automatic measure_gap(output int n);
    frame_end_i = 1'b1;
    step();
    frame_end_i = 1'b0;
    n = 1;
    while (!tx_ready_o && n < 300) begin
      step();
      n++;
    end
  endtask

  task automatic t_reset();
    check("R1 ready", tx_ready_o, 1);
    check("R1 start", tx_start_o, 0);
    check("R1 rdata", reg_rdata_o, 32'h12);
  endtask

  task automatic t_default_gap();
    int n;
    measure_gap(n);
    check("R2 default gap", n, 24);
  endtask

  task automatic t_field_values();
    int n;
    int f[6] = '{1, 5, 9, 13, 29, 127};
    int g[6] = '{7, 11, 15, 19, 35, 133};
    write_field(32'h0);
    measure_gap(n);
    check("R3 zero field gap", n, 6);
    for (int i = 0; i < 6; i++) begin
      write_field(32'(f[i]));
      measure_gap(n);
      check(i == 5 ? "R9 max gap" : "R2 field gap", n, g[i]);
    end
  endtask

  task automatic t_register();
    reg_we_i = 1'b1;
    reg_wdata_i = 32'hFFFF_FF85;
    #1;
    check("R8 old value during write", reg_rdata_o, 32'd127);
    step();
    reg_we_i = 1'b0;
    check("R7 reserved ignored", reg_rdata_o, 32'h05);
    write_field(32'h12);
    check("R8 write visible", reg_rdata_o, 32'h12);
  endtask

  task automatic t_hold();
    int early = 0;
    frame_end_i = 1'b1;
    step();
    frame_end_i = 1'b0;
    step();
    tx_req_i = 1'b1;
    if (tx_start_o) early++;
    step();
    tx_req_i = 1'b0;
    for (int c = 3; c < 24; c++) begin
      if (tx_start_o || tx_ready_o) early++;
      step();
    end
    check("R4 no early start", early, 0);
    check("R4 start at gap end", tx_start_o, 1);
    step();
    check("R10 single pulse", tx_start_o, 0);
    check("R5 ready low after start", tx_ready_o, 0);
  endtask

  task automatic t_immediate();
    int n;
    // leave the frame from t_hold: close it with a gap first
    measure_gap(n);
    check("R2 gap after held frame", n, 24);
    tx_req_i = 1'b1;
    #1;
    check("R5 same-clock start", tx_start_o, 1);
    step();
    tx_req_i = 1'b0;
    check("R5 ready low in frame", tx_ready_o, 0);
    check("R10 no repeat start", tx_start_o, 0);
    for (int i = 0; i < 40; i++) step();
    check("R5 ready low until frame end", tx_ready_o, 0);
    measure_gap(n);
    check("R5 gap after frame", n, 24);
  endtask

  task automatic t_write_during_gap();
    int n;
    frame_end_i = 1'b1;
    step();
    frame_end_i = 1'b0;
    step();
    step();
    write_field(32'h0);
    n = 4;
    while (!tx_ready_o && n < 300) begin
      step();
      n++;
    end
    check("R6 current gap kept", n, 24);
    measure_gap(n);
    check("R6 next gap uses new value", n, 6);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_default_gap();
    t_field_values();
    t_register();
    t_hold();
    t_immediate();
    write_field(32'h12);
    t_write_during_gap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule